// File: doc/BRIEF.md
# Dual-Length Serial Register-Access Slave

This block is the serial front end of a register-access port. It acts as a mode-0 SPI slave: SCLK idles low, SDI is sampled on the rising SCLK edge, SDO changes on the falling edge, and bits travel most significant first. One chip-select window carries either a short frame of 24 bits or a long frame of 32 bits. The slave works out which one it received by counting the SCLK rising edges seen while CS_N is low. In a short frame the master sends an address byte and then a 16-bit data word. A long frame adds one leading pad byte before the address. That pad byte is discarded whatever its value. A pad byte other than zero raises a warning flag.

On the return path the slave sends a status byte and a 16-bit response word. Both are sampled from the register file when chip-select falls. In a long frame a zero byte sits between the status byte and the response word, so the response word lands in the last two bytes of the frame. The slave must start shifting before it knows how long the current frame will be. It therefore picks the return layout from the length of the last valid frame. A master that keeps one frame length gets the matching layout every time.

A frame is processed when chip-select rises. A valid frame updates the address and data outputs together with a one-cycle done strobe. Any other bit count produces a one-cycle length-error strobe instead, and the frame is dropped. The serial inputs are oversampled by the system clock through synchronizers. SCLK must therefore be slower than about one eighth of the system clock.

Top module: `spi_dual_len_slave`

## Requirements
- R1: After reset, sdo, sdo_oe, frame_done, len_err, long_frame and pad_warn are 0, and frame_addr and frame_wdata are all zeros.
- R2: While cs_n is high, sdo_oe is 0 and sdo is 0. While a frame is in progress, sdo_oe is 1.
- R3: A window of exactly 24 SCLK rising edges is a short frame. The first 8 SDI bits form frame_addr and the next 16 form frame_wdata, MSB first. Both outputs update in the same cycle as a one-cycle frame_done pulse, and long_frame becomes 0.
- R4: A window of exactly 32 rising edges is a long frame. The first 8 bits are dropped, the next 8 form frame_addr and the last 16 form frame_wdata. The outputs update with a frame_done pulse, and long_frame becomes 1.
- R5: pad_warn is updated at each valid frame. It is 1 only for a long frame whose first byte is not 0x00, and 0 otherwise, including after every short frame.
- R6: A window whose edge count is neither 24 nor 32 gives one len_err pulse and no frame_done. This includes 0 edges and counts beyond the 63 the counter saturates at. frame_addr, frame_wdata, long_frame and pad_warn keep their values.
- R7: With the short return layout, SDO carries the status byte and then the response word, MSB first, both sampled at the falling edge of cs_n. Any bits after the 24th are 0.
- R8: With the long return layout, SDO carries the status byte, then 8 zero bits, then the response word. Any bits after the 32nd are 0.
- R9: The return layout of a frame is long exactly when the last valid frame before it was long. It is short after reset, and length-error frames do not change it.
- R10: frame_done and len_err are never high in the same cycle, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial clock from the master, idles low |
| cs_n | input | 1 | Active-low chip select that frames one transfer |
| sdi | input | 1 | Serial data from the master |
| status_in | input | 8 | Status byte, sampled at the falling edge of cs_n |
| resp_in | input | 16 | Response word, sampled at the falling edge of cs_n |
| sdo | output | 1 | Serial data to the master, 0 when not enabled |
| sdo_oe | output | 1 | Output enable for the SDO pad driver |
| frame_done | output | 1 | One-cycle strobe when a valid frame is decoded |
| frame_addr | output | 8 | Address byte of the last valid frame |
| frame_wdata | output | 16 | Data word of the last valid frame |
| len_err | output | 1 | One-cycle strobe when a frame had an illegal length |
| long_frame | output | 1 | 1 when the last valid frame was 32 bits long |
| pad_warn | output | 1 | Last valid frame was long with a nonzero pad byte |

## Verification
The bench builds the block with its default widths: an 8-bit address, a 16-bit word, an 8-bit pad and two synchronizer stages. With these widths the bench can sweep every frame length from 0 to 40 bits, plus a 70-bit burst that saturates the counter, so each illegal count next to 24 and 32 is tried. Short and long frames are interleaved, so every change of return layout is exercised, including the first long frame after a short one, which still gets the short layout. Every SDO bit of every frame is compared against a word the bench builds from the requirement layouts.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_SHORT = 2'd1,
    FK_LONG  = 2'd2,
    FK_BAD   = 2'd3
  } frame_kind_e;

  // Classify a finished window by its edge count.
  function automatic frame_kind_e classify_len(input int count,
                                               input int short_n,
                                               input int long_n);
    if (count == short_n)     return FK_SHORT;
    else if (count == long_n) return FK_LONG;
    else                      return FK_BAD;
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_rx_deframe.sv
module spi_rx_deframe
  import spi_dual_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int PAD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sdi_bit,
  output logic              frame_done,
  output logic              len_err,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              long_frame,
  output logic              pad_warn
);

  localparam int SHORT_N = ADDR_W + DATA_W;
  localparam int LONG_N  = SHORT_N + PAD_W;
  localparam int CNT_W   = $clog2(2 * LONG_N);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LONG_N-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q,   cnt_d;
  logic              done_q,  done_d;
  logic              err_q,   err_d;
  logic [ADDR_W-1:0] addr_q,  addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              long_q,  long_d;
  logic              warn_q,  warn_d;
  frame_kind_e       kind;

  assign kind = cs_rise ? classify_len(int'(cnt_q), SHORT_N, LONG_N) : FK_NONE;

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    long_d  = long_q;
    warn_d  = warn_q;

    if (cs_fall) begin
      cnt_d = '0;
    end else if (cs_active && sclk_rise) begin
      shreg_d = {shreg_q[LONG_N-2:0], sdi_bit};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    unique case (kind)
      FK_SHORT: begin
        done_d  = 1'b1;
        addr_d  = shreg_q[DATA_W +: ADDR_W];
        wdata_d = shreg_q[0 +: DATA_W];
        long_d  = 1'b0;
        warn_d  = 1'b0;
      end
      FK_LONG: begin
        done_d  = 1'b1;
        addr_d  = shreg_q[DATA_W +: ADDR_W];
        wdata_d = shreg_q[0 +: DATA_W];
        long_d  = 1'b1;
        warn_d  = |shreg_q[SHORT_N +: PAD_W];
      end
      FK_BAD:  err_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      long_q  <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      err_q   <= err_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      long_q  <= long_d;
      warn_q  <= warn_d;
    end
  end

  assign frame_done = done_q;
  assign len_err    = err_q;
  assign addr       = addr_q;
  assign wdata      = wdata_q;
  assign long_frame = long_q;
  assign pad_warn   = warn_q;

endmodule

// File: rtl/spi_tx_serializer.sv
module spi_tx_serializer #(
  parameter int STAT_W = 8,
  parameter int DATA_W = 16,
  parameter int PAD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              cs_fall,
  input  logic              sclk_fall,
  input  logic              wide_sel,
  input  logic [STAT_W-1:0] status,
  input  logic [DATA_W-1:0] resp,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int TX_W = STAT_W + PAD_W + DATA_W;

  logic [TX_W-1:0] tx_q, tx_d;
  logic [TX_W-1:0] load_word;

  assign load_word = wide_sel ? {status, {PAD_W{1'b0}}, resp}
                              : {status, resp, {PAD_W{1'b0}}};

  always_comb begin
    tx_d = tx_q;
    if (cs_fall)                     tx_d = load_word;
    else if (!cs_active)             tx_d = '0;
    else if (sclk_fall)              tx_d = {tx_q[TX_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else        tx_q <= tx_d;
  end

  assign sdo_oe = cs_active;
  assign sdo    = cs_active & tx_q[TX_W-1];

endmodule

// File: rtl/spi_dual_len_slave.sv
module spi_dual_len_slave #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int STAT_W      = 8,
  parameter int PAD_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic [STAT_W-1:0] status_in,
  input  logic [DATA_W-1:0] resp_in,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              frame_done,
  output logic [ADDR_W-1:0] frame_addr,
  output logic [DATA_W-1:0] frame_wdata,
  output logic              len_err,
  output logic              long_frame,
  output logic              pad_warn
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  // Bit order: [2] sdi, [1] cs_n, [0] sclk.
  logic [2:0] pins_s;
  spi_in_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk  (clk),
    .rst_n(core_rst_n),
    .d    ({sdi, cs_n, sclk}),
    .q    (pins_s)
  );

  logic sclk_d, cs_d;
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= pins_s[0];
      cs_d   <= pins_s[1];
    end
  end

  logic sclk_rise, sclk_fall, cs_fall, cs_rise, cs_active;
  assign sclk_rise = pins_s[0] & ~sclk_d;
  assign sclk_fall = ~pins_s[0] & sclk_d;
  assign cs_fall   = ~pins_s[1] & cs_d;
  assign cs_rise   = pins_s[1] & ~cs_d;
  assign cs_active = ~pins_s[1];

  logic long_q;

  spi_rx_deframe #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .PAD_W (PAD_W)
  ) u_rx (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .cs_active (cs_active),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sclk_rise (sclk_rise),
    .sdi_bit   (pins_s[2]),
    .frame_done(frame_done),
    .len_err   (len_err),
    .addr      (frame_addr),
    .wdata     (frame_wdata),
    .long_frame(long_q),
    .pad_warn  (pad_warn)
  );

  spi_tx_serializer #(
    .STAT_W(STAT_W),
    .DATA_W(DATA_W),
    .PAD_W (PAD_W)
  ) u_tx (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .cs_active(cs_active),
    .cs_fall  (cs_fall),
    .sclk_fall(sclk_fall),
    .wide_sel (long_q),
    .status   (status_in),
    .resp     (resp_in),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
  );

  assign long_frame = long_q;

endmodule

// File: rtl/spi_dual_len_slave_chk.sv
module spi_dual_len_slave_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdo,
  input logic              sdo_oe,
  input logic              frame_done,
  input logic              len_err,
  input logic              long_frame,
  input logic              pad_warn,
  input logic [ADDR_W-1:0] frame_addr,
  input logic [DATA_W-1:0] frame_wdata
);

  // R2
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && len_err));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R10
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> !len_err);

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> ($stable(frame_addr) && $stable(frame_wdata)));

  // R5
  warn_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_warn |-> long_frame);

endmodule

bind spi_dual_len_slave spi_dual_len_slave_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sdo        (sdo),
  .sdo_oe     (sdo_oe),
  .frame_done (frame_done),
  .len_err    (len_err),
  .long_frame (long_frame),
  .pad_warn   (pad_warn),
  .frame_addr (frame_addr),
  .frame_wdata(frame_wdata)
);

// File: tb/tb_spi_dual_len_slave.sv
module tb_spi_dual_len_slave;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic [7:0]  status_in = '0;
  logic [15:0] resp_in = '0;
  logic        sdo, sdo_oe, frame_done, len_err, long_frame, pad_warn;
  logic [7:0]  frame_addr;
  logic [15:0] frame_wdata;

  always #5 clk = ~clk;

  spi_dual_len_slave dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .status_in(status_in), .resp_in(resp_in), .sdo(sdo), .sdo_oe(sdo_oe),
    .frame_done(frame_done), .frame_addr(frame_addr), .frame_wdata(frame_wdata),
    .len_err(len_err), .long_frame(long_frame), .pad_warn(pad_warn)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Bench model state
  logic        m_wide = 1'b0;
  logic [7:0]  m_addr = '0;
  logic [15:0] m_data = '0;
  logic        m_long = 1'b0;
  logic        m_warn = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input int nbits, input logic [79:0] mosi,
                      input logic [7:0] st, input logic [15:0] rs);
    logic [31:0] exp_w;
    int mism = 0;
    int n_done = 0;
    int n_err = 0;
    bit valid;
    string lay_req;
    exp_w   = m_wide ? {st, 8'h00, rs} : {st, rs, 8'h00};
    lay_req = m_wide ? "R8" : "R7";
    @(negedge clk);
    status_in = st;
    resp_in   = rs;
    cs_n      = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      logic eb;
      sdi = mosi[nbits-1-i];
      repeat (4) @(negedge clk);
      eb = (i < 32) ? exp_w[31-i] : 1'b0;
      if (sdo !== eb || sdo_oe !== 1'b1) mism++;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (frame_done) n_done++;
      if (len_err)    n_err++;
    end
    chk(mism == 0, lay_req, $sformatf("sdo bits wrong in %0d-bit frame", nbits),
        mism, 0);
    valid = (nbits == 24) || (nbits == 32);
    if (valid) begin
      m_addr = mosi[23:16];
      m_data = mosi[15:0];
      m_long = (nbits == 32);
      m_warn = (nbits == 32) && (mosi[31:24] != 8'h00);
      m_wide = m_long;  // R9
    end
    if (nbits == 24) begin
      chk(n_done == 1 && n_err == 0, "R3", "done/err pulses", {n_done[15:0], n_err[15:0]}, 32'h0001_0000);
    end else if (nbits == 32) begin
      chk(n_done == 1 && n_err == 0, "R4", "done/err pulses", {n_done[15:0], n_err[15:0]}, 32'h0001_0000);
    end else begin
      chk(n_done == 0 && n_err == 1, "R6", $sformatf("len %0d done/err pulses", nbits),
          {n_done[15:0], n_err[15:0]}, 32'h0000_0001);
    end
    chk(frame_addr == m_addr, valid ? (nbits == 24 ? "R3" : "R4") : "R6", "frame_addr",
        frame_addr, m_addr);
    chk(frame_wdata == m_data, valid ? (nbits == 24 ? "R3" : "R4") : "R6", "frame_wdata",
        frame_wdata, m_data);
    chk(long_frame == m_long, "R9", "long_frame", long_frame, m_long);
    chk(pad_warn == m_warn, "R5", "pad_warn", pad_warn, m_warn);
    chk(sdo_oe == 1'b0 && sdo == 1'b0, "R2", "sdo/sdo_oe idle", {sdo_oe, sdo}, 0);
  endtask

  function automatic logic [79:0] pat(input int seed);
    logic [63:0] a;
    a = 64'h9E37_79B9_7F4A_7C15 * (seed + 1);
    return {a[15:0], a ^ {a[31:0], a[63:32]}};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge clk);
    // R1 reset values while held and just after release
    chk(sdo == 0 && sdo_oe == 0 && frame_done == 0 && len_err == 0, "R1",
        "strobes/sdo in reset", {sdo, sdo_oe, frame_done, len_err}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(frame_addr == 0 && frame_wdata == 0, "R1", "addr/wdata after reset",
        {frame_addr, frame_wdata}, 0);
    chk(long_frame == 0 && pad_warn == 0, "R1", "long/warn after reset",
        {long_frame, pad_warn}, 0);
    chk(sdo_oe == 0 && sdo == 0, "R2", "idle sdo", {sdo_oe, sdo}, 0);

    // Directed frames
    xfer(24, 80'h00_0000_0000_00A5_1234, 8'h81, 16'hBEEF);        // R3 R7
    xfer(32, 80'h00_0000_0000_005A_C3F0, 8'h42, 16'h1357);        // R4, layout still short (R9)
    xfer(32, 80'h00_0000_0000_3C66_9009, 8'hE7, 16'h2468);        // R5 warn, R8
    xfer(23, 80'h00_0000_0000_0012_3456, 8'h11, 16'h7777);        // R6 keeps long layout
    xfer(32, 80'h00_0000_0000_0001_0203, 8'h99, 16'hF00D);        // R8 after error
    xfer(24, 80'h00_0000_0000_00FF_0000, 8'h00, 16'h0000);        // R5 cleared, R3
    xfer(70, pat(99), 8'h55, 16'hAAAA);                           // R6 counter saturation

    // Length sweep 0..40
    for (int n = 0; n <= 40; n++) begin
      logic [79:0] v;
      v = pat(n);
      xfer(n, v, v[7:0] ^ 8'h3C, v[31:16]);
    end

    // Address sweep alternating lengths
    for (int a = 0; a < 16; a++) begin
      logic [79:0] v;
      v = pat(a + 200);
      v[23:16] = 8'(a * 17);
      if (a % 3 == 0) v[31:24] = 8'h00;
      xfer((a % 2 == 0) ? 32 : 24, v, 8'(a * 5), v[47:32]);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule